// File: doc/BRIEF.md
# Cascadable Up/Down Counter with Clocked Carry

This block is a small synchronous counter whose direction is chosen on every cycle. A parameter selects one of two variants: a decade counter that runs through 0 to 9, or a binary counter that uses the full range of its word. The counter can be cleared at once, cleared at the next edge, or loaded in parallel. It advances only when two active-low enables are both asserted.

Two active-low carry outputs let several counters be chained into a wider one. The ripple carry is combinational. It goes low at the terminal value for the current direction, but only while the second enable (T) is asserted. The clocked carry is a cleaner pulse that is gated by the low phase of the clock and by both enables. To build a wider counter, either carry of one stage is wired to the T enable of the next stage.

The count is presented as a data word together with a drive-enable flag, which a pad ring can turn into a three-state driver. The drive-enable flag never disturbs the counting.

Top module: `udc_counter`

## Requirements
- R1: With both clears high and `load_n` low, a rising clock edge places `data_in` into the count.
- R2: A low on `aclr_n` forces the count to zero at once, without waiting for a clock edge, and overrides every other input.
- R3: With `aclr_n` high and `sclr_n` low, the count is zero after the next rising edge, whatever the values of load and the enables.
- R4: The count changes on an edge only when `enp_n` and `ent_n` are both low and `aclr_n`, `sclr_n` and `load_n` are all high. Otherwise the count keeps its value.
- R5: `dir_up` = 1 counts up by one and `dir_up` = 0 counts down by one. The binary variant (DECADE = 0) wraps from 15 to 0 going up and from 0 to 15 going down.
- R6: The decade variant (DECADE = 1) wraps from 9 to 0 going up and from 0 to 9 going down.
- R7: In the decade variant, a loaded value from 10 to 15 goes to 0 on an enabled up step and down by one on an enabled down step. While the count is in that range, `rco_n` stays high.
- R8: `rco_n` is low exactly when `ent_n` is low and the count is at its terminal value for the direction: 9 (decade) or 15 (binary) when counting up, 0 when counting down. `enp_n` has no effect on it.
- R9: `cco_n` is low only while `clk` is low, `rco_n` is low and both enables are low. It is high at all other times.
- R10: `q_drive_en` equals the inverse of `oe_n`. The value of `oe_n` never changes the count.
- R11: When the `rco_n` of one binary stage feeds the `ent_n` of a second stage, the pair counts as one 8-bit counter in both directions, and the upper stage's `rco_n` marks the 8-bit terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every synchronous action happens on its rising edge |
| aclr_n | input | 1 | Asynchronous clear, active low |
| sclr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Parallel load, active low |
| data_in | input | WIDTH | Value to load |
| enp_n | input | 1 | Count enable P, active low |
| ent_n | input | 1 | Count enable T, active low; also gates the ripple carry |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| oe_n | input | 1 | Output enable, active low |
| q | output | WIDTH | Current count |
| q_drive_en | output | 1 | High when `q` should be driven onto a bus |
| rco_n | output | 1 | Ripple carry, active low, combinational |
| cco_n | output | 1 | Clocked carry, active low, valid only in the low clock phase |

## Verification
Clear, load and count take effect at the first rising edge after the inputs are applied, because one register lies in the path. The bench therefore changes its inputs in the low clock phase, updates its reference model at the rising edge, and compares the count one nanosecond later and again in the following low phase.

Two results need no clock edge. The ripple carry follows the inputs and the count combinationally. The asynchronous clear acts at once, so it is checked half a nanosecond after `aclr_n` falls, before any edge arrives. The clocked carry is compared in both clock phases: it must be high shortly after each rising edge and must match the model in the middle of the low phase.

// File: rtl/udc_pkg.sv
package udc_pkg;
   // Action taken at the next rising edge, in priority order.
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_COUNT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } udc_op_e;
endpackage

// File: rtl/udc_ctrl.sv
module udc_ctrl
   import udc_pkg::*;
(
   input  logic    sclr_n,
   input  logic    load_n,
   input  logic    enp_n,
   input  logic    ent_n,
   output udc_op_e op
);
   // Synchronous clear beats load, and load beats count.
   always_comb begin
      if (!sclr_n)               op = OP_CLEAR;
      else if (!load_n)          op = OP_LOAD;
      else if (!enp_n && !ent_n) op = OP_COUNT;
      else                       op = OP_HOLD;
   end
endmodule

// File: rtl/udc_step.sv
module udc_step #(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input  logic [WIDTH-1:0] cnt,
   input  logic             dir_up,
   output logic [WIDTH-1:0] nxt,
   output logic             at_term
);
   localparam logic [WIDTH-1:0] TOP  = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ZERO = '0;

   generate
      if (DECADE) begin : g_dec
         // Any value at or above 9 goes to zero on an up step.
         always_comb begin
            if (dir_up) nxt = (cnt >= TOP) ? ZERO : cnt + WIDTH'(1);
            else        nxt = (cnt == ZERO) ? TOP : cnt - WIDTH'(1);
         end
      end else begin : g_bin
         // The natural wrap of the word gives the modulus.
         always_comb begin
            if (dir_up) nxt = cnt + WIDTH'(1);
            else        nxt = cnt - WIDTH'(1);
         end
      end
   endgenerate

   assign at_term = dir_up ? (cnt == TOP) : (cnt == ZERO);
endmodule

// File: rtl/udc_carry.sv
module udc_carry (
   input  logic clk,
   input  logic aclr_n,
   input  logic at_term,
   input  logic enp_n,
   input  logic ent_n,
   output logic rco_n,
   output logic cco_n
);
   logic rco_int;

   // Only the T enable gates the ripple carry.
   assign rco_int = ~(at_term & ~ent_n);
   assign rco_n   = rco_int;
   // Clocked carry: pulses low only in the low clock phase.
   assign cco_n   = ~(~clk & ~rco_int & ~enp_n & ~ent_n);

   a_r8_t_gates_rco: assert property (@(posedge clk) disable iff (!aclr_n)
      ent_n |-> rco_n);
   a_r9_cco_needs_all: assert property (@(posedge clk) disable iff (!aclr_n)
      !cco_n |-> (!rco_n && !enp_n && !ent_n));
endmodule

// File: rtl/udc_counter.sv
module udc_counter
   import udc_pkg::*;
#(
   parameter int WIDTH  = 4,
   parameter bit DECADE = 1'b0
) (
   input  logic             clk,
   input  logic             aclr_n,
   input  logic             sclr_n,
   input  logic             load_n,
   input  logic [WIDTH-1:0] data_in,
   input  logic             enp_n,
   input  logic             ent_n,
   input  logic             dir_up,
   input  logic             oe_n,
   output logic [WIDTH-1:0] q,
   output logic             q_drive_en,
   output logic             rco_n,
   output logic             cco_n
);
   localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("udc_counter: WIDTH must be at least 1");
      end
      if (DECADE && WIDTH < 4) begin : g_bad_decade
         $error("udc_counter: the decade variant needs WIDTH >= 4");
      end
   endgenerate

   udc_op_e          op;
   logic [WIDTH-1:0] cnt;
   logic [WIDTH-1:0] nxt;
   logic             at_term;

   udc_ctrl u_ctrl (
      .sclr_n (sclr_n),
      .load_n (load_n),
      .enp_n  (enp_n),
      .ent_n  (ent_n),
      .op     (op)
   );

   udc_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
      .cnt     (cnt),
      .dir_up  (dir_up),
      .nxt     (nxt),
      .at_term (at_term)
   );

   udc_carry u_carry (
      .clk     (clk),
      .aclr_n  (aclr_n),
      .at_term (at_term),
      .enp_n   (enp_n),
      .ent_n   (ent_n),
      .rco_n   (rco_n),
      .cco_n   (cco_n)
   );

   always_ff @(posedge clk or negedge aclr_n) begin
      if (!aclr_n) begin
         cnt <= '0;
      end else begin
         unique case (op)
            OP_CLEAR: cnt <= '0;
            OP_LOAD:  cnt <= data_in;
            OP_COUNT: cnt <= nxt;
            default:  cnt <= cnt;
         endcase
      end
   end

   assign q          = cnt;
   assign q_drive_en = ~oe_n;

   a_r3_sync_clear: assert property (@(posedge clk) disable iff (!aclr_n)
      !sclr_n |=> (q == '0));
   a_r1_load: assert property (@(posedge clk) disable iff (!aclr_n)
      (sclr_n && !load_n) |=> (q == $past(data_in)));
   a_r4_hold: assert property (@(posedge clk) disable iff (!aclr_n)
      (sclr_n && load_n && (enp_n || ent_n)) |=> $stable(q));
   a_r5_up_step: assert property (@(posedge clk) disable iff (!aclr_n)
      (sclr_n && load_n && !enp_n && !ent_n && dir_up && q < TOP)
      |=> (q == $past(q) + WIDTH'(1)));
   a_r7_out_of_range_quiet: assert property (@(posedge clk) disable iff (!aclr_n)
      (q > TOP) |-> rco_n);
endmodule

// File: tb/udc_counter_bench.sv
`timescale 1ns/100ps
module udc_counter_bench;
   logic       clk = 1'b0;
   logic       aclr_n, sclr_n, load_n, enp_n, ent_n, dir_up, oe_n;
   logic [7:0] data;
   logic [3:0] ql, qh, qd;
   logic       del, deh, ded;
   logic       rco_l, rco_h, rco_d, cco_l, cco_h, cco_d;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    c8 = 0;
   int    cd = 0;
   string tag = "R2 reset";

   always #2 clk = ~clk;

   // Lower binary stage; the design under test.
   udc_counter #(.WIDTH(4), .DECADE(1'b0)) u_udc_counter (
      .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n),
      .data_in(data[3:0]), .enp_n(enp_n), .ent_n(ent_n), .dir_up(dir_up),
      .oe_n(oe_n), .q(ql), .q_drive_en(del), .rco_n(rco_l), .cco_n(cco_l));

   // Upper binary stage, enabled by the lower stage's ripple carry.
   udc_counter #(.WIDTH(4), .DECADE(1'b0)) u_hi (
      .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n),
      .data_in(data[7:4]), .enp_n(enp_n), .ent_n(rco_l), .dir_up(dir_up),
      .oe_n(oe_n), .q(qh), .q_drive_en(deh), .rco_n(rco_h), .cco_n(cco_h));

   // Decade variant that shares the inputs.
   udc_counter #(.WIDTH(4), .DECADE(1'b1)) u_dec (
      .clk(clk), .aclr_n(aclr_n), .sclr_n(sclr_n), .load_n(load_n),
      .data_in(data[3:0]), .enp_n(enp_n), .ent_n(ent_n), .dir_up(dir_up),
      .oe_n(oe_n), .q(qd), .q_drive_en(ded), .rco_n(rco_d), .cco_n(cco_d));

   task automatic chk(input int act, input int exp, input string what);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_rco(input int v, input int top);
      if (ent_n) return 1;
      return (dir_up ? (v == top) : (v == 0)) ? 0 : 1;
   endfunction

   // Full comparison in the low clock phase.
   task automatic check_low();
      int rl, rh, rd;
      rl = exp_rco(c8 % 16, 15);
      rh = (rl == 0) ? ((dir_up ? (c8 / 16 == 15) : (c8 / 16 == 0)) ? 0 : 1) : 1;
      rd = exp_rco(cd, 9);
      chk({qh, ql}, c8, "R11 8-bit count");
      chk(qd, cd, "R6 decade count");
      chk(rco_l, rl, "R8 low rco");
      chk(rco_h, rh, "R11 high rco");
      chk(rco_d, rd, "R8 decade rco");
      chk(cco_l, (rl == 0 && !enp_n && !ent_n) ? 0 : 1, "R9 low cco");
      chk(cco_d, (rd == 0 && !enp_n && !ent_n) ? 0 : 1, "R9 decade cco");
      chk(del, !oe_n, "R10 drive enable");
      chk(ded, !oe_n, "R10 decade drive enable");
   endtask

   // One cycle: model at the rising edge, checks after it and in the low phase.
   task automatic cyc();
      @(posedge clk);
      if (!aclr_n || !sclr_n) begin
         c8 = 0; cd = 0;
      end else if (!load_n) begin
         c8 = data; cd = data % 16;
      end else if (!enp_n && !ent_n) begin
         if (dir_up) begin
            c8 = (c8 + 1) % 256;
            cd = (cd >= 9) ? 0 : cd + 1;
         end else begin
            c8 = (c8 + 255) % 256;
            cd = (cd == 0) ? 9 : cd - 1;
         end
      end
      #1;
      chk(cco_l, 1, "R9 low cco in high phase");
      chk(cco_d, 1, "R9 decade cco in high phase");
      chk(qd, cd, "R4 decade count after edge");
      @(negedge clk);
      #1;
      check_low();
   endtask

   task automatic set_in(input logic s, input logic l, input logic p,
                         input logic t, input logic u, input logic [7:0] d);
      sclr_n = s; load_n = l; enp_n = p; ent_n = t; dir_up = u; data = d;
   endtask

   initial begin
      #150000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      aclr_n = 1'b0; oe_n = 1'b1;
      set_in(1, 1, 1, 1, 1, 8'h00);
      #1;
      chk({qh, ql}, 0, "R2 reset state");
      chk(qd, 0, "R2 decade reset state");
      cyc();
      cyc();
      @(negedge clk); #1;
      aclr_n = 1'b1;

      tag = "R1 load";
      set_in(1, 0, 0, 0, 1, 8'hF5);
      cyc();

      tag = "R5 R6 R10 count up";
      set_in(1, 1, 0, 0, 1, 8'h00);
      for (int i = 0; i < 24; i++) begin
         oe_n = i[2];
         cyc();
      end

      tag = "R1 load low";
      set_in(1, 0, 0, 0, 0, 8'h03);
      cyc();
      tag = "R5 R6 R11 count down";
      set_in(1, 1, 0, 0, 0, 8'h00);
      for (int i = 0; i < 24; i++) begin
         oe_n = i[1];
         cyc();
      end

      tag = "R1 load terminal";
      set_in(1, 0, 0, 0, 1, 8'hFF);
      cyc();
      tag = "R4 R8 R9 enp high holds";
      set_in(1, 1, 1, 0, 1, 8'h00);
      for (int i = 0; i < 4; i++) cyc();
      tag = "R4 R8 ent high holds";
      set_in(1, 1, 0, 1, 1, 8'h00);
      for (int i = 0; i < 4; i++) cyc();
      tag = "R4 R8 both high";
      set_in(1, 1, 1, 1, 0, 8'h00);
      for (int i = 0; i < 3; i++) cyc();

      tag = "R3 sync clear beats load and count";
      set_in(0, 0, 0, 0, 1, 8'h77);
      cyc();
      tag = "R1 load beats count";
      set_in(1, 0, 0, 0, 1, 8'h5A);
      cyc();

      tag = "R7 decade 12 up";
      set_in(1, 0, 0, 0, 1, 8'hAC);
      cyc();
      set_in(1, 1, 0, 0, 1, 8'h00);
      cyc();
      cyc();
      tag = "R7 decade 13 down";
      set_in(1, 0, 0, 0, 0, 8'h0D);
      cyc();
      set_in(1, 1, 0, 0, 0, 8'h00);
      for (int i = 0; i < 5; i++) cyc();
      tag = "R7 decade 15 down at T";
      set_in(1, 0, 0, 0, 0, 8'h0F);
      cyc();
      set_in(1, 1, 1, 0, 1, 8'h00);
      cyc();

      tag = "R1 load before clear";
      set_in(1, 0, 0, 0, 1, 8'h96);
      cyc();
      set_in(1, 1, 0, 0, 1, 8'h00);
      tag = "R2 async clear";
      aclr_n = 1'b0;
      #0.5;
      chk({qh, ql}, 0, "R2 immediate clear");
      chk(qd, 0, "R2 decade immediate clear");
      cyc();
      @(negedge clk); #1;
      aclr_n = 1'b1;
      tag = "R11 count after clear";
      for (int i = 0; i < 20; i++) cyc();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule